// File: doc/BRIEF.md
# Home Node Coherence Directory

This block is the directory controller at the home node of a group of memory blocks in an invalidation-based coherence scheme for distributed shared memory. Requesting nodes send read, read-exclusive and upgrade requests, each with the node number of the requester and the index of the block. For every block the directory keeps a state (uncached, shared or modified), a pointer to the owning node and a full sharer vector with one bit per node.

When the directory accepts a request it updates the block's entry in that same cycle. The request counts as complete at that point, and the directory does not wait for acknowledgements. It then sends out the messages the request calls for. Invalidations go only to the nodes recorded as sharers. A request that meets a block held modified by another node sends an intervention to that owner, so a dirty copy can be shared without first being written back. A reply with data, or a grant without data, goes back to the requester. Messages leave one per cycle through a valid/ready handshake. No new request is accepted until the last message of the current one has gone, so requests to the same block never overlap.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every block is uncached, `req_ready` is 1 and `msg_valid` is 0.
- R2: A read from a node that does not own the block, when the block is uncached or shared, produces a data reply (msg_kind 2) to the requester. The requester is added to the sharer vector and the block becomes shared. Request kinds: read=0, read-exclusive=1, upgrade=2; kind 3 is handled as a read.
- R3: A read that meets a block held modified by another node produces one intervention (msg_kind 1) to the owner, with `msg_req` set to the requester. The block becomes shared, and its sharers are the old owner and the requester.
- R4: A read-exclusive from a non-owner, to a block that is not modified, invalidates every other recorded sharer and then sends a data reply. The requester becomes the only sharer and the owner, and the block becomes modified.
- R5: Invalidations (msg_kind 0) go exactly to the recorded sharers other than the requester, one per message, in ascending node order. No invalidation is ever sent to a node that is not a recorded sharer.
- R6: An upgrade from a node recorded as a sharer of a shared block invalidates the other sharers and then sends a grant without data (msg_kind 3). The requester becomes the owner.
- R7: An upgrade from a node that is not in the sharer vector is handled exactly as a read-exclusive.
- R8: A read-exclusive or upgrade that meets a block held modified by another node produces one intervention to the old owner, and the requester becomes the owner.
- R9: Any request from the current owner of a modified block produces one grant without data and leaves the entry unchanged.
- R10: `req_ready` is 0 from the cycle after a request is accepted until the final message of that request has been handed over. A following request sees the updated entry.
- R11: While `msg_valid` is 1 and `msg_ready` is 0, the message and its fields stay unchanged.
- R12: An entry changes only through requests that name its own block index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_kind | input | 2 | 0 read, 1 read-exclusive, 2 upgrade |
| req_node | input | 3 | Requesting node |
| req_blk | input | 4 | Block index |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network takes the message |
| msg_kind | output | 2 | 0 invalidate, 1 intervention, 2 data reply, 3 grant without data |
| msg_dst | output | 3 | Destination node |
| msg_req | output | 3 | Node whose request caused the message |
| msg_blk | output | 4 | Block index |

## Verification
A request is accepted at the rising edge where `req_valid` and `req_ready` are both 1. Its first message is visible on the output in the cycle that follows, and each later message follows one cycle after the previous one was taken. `req_ready` comes back in the cycle after the final handshake. The bench drives inputs and samples outputs at falling edges, checks one message per handshake against a directory model it keeps itself, and checks `msg_valid` low and `req_ready` high right after the final message. On stalled requests it holds `msg_ready` low for one cycle before each message and checks that the message is still presented after the stall.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {
    ST_UNC = 2'd0,
    ST_SHD = 2'd1,
    ST_MOD = 2'd2
  } blk_state_e;

  localparam logic [1:0] RQ_READ = 2'd0;
  localparam logic [1:0] RQ_RDX  = 2'd1;
  localparam logic [1:0] RQ_UPG  = 2'd2;

  localparam logic [1:0] MS_INV  = 2'd0;
  localparam logic [1:0] MS_INTV = 2'd1;
  localparam logic [1:0] MS_DATA = 2'd2;
  localparam logic [1:0] MS_ACK  = 2'd3;
endpackage

// File: rtl/coh_dir_table.sv
module coh_dir_table
  import coh_dir_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int BLOCKS = 16,
  localparam int NW = $clog2(NODES),
  localparam int BW = $clog2(BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    rd_idx,
  output blk_state_e       rd_st,
  output logic [NW-1:0]    rd_own,
  output logic [NODES-1:0] rd_shr,
  input  logic             wr_en,
  input  logic [BW-1:0]    wr_idx,
  input  blk_state_e       wr_st,
  input  logic [NW-1:0]    wr_own,
  input  logic [NODES-1:0] wr_shr
);
  blk_state_e       st_q  [BLOCKS];
  logic [NW-1:0]    own_q [BLOCKS];
  logic [NODES-1:0] shr_q [BLOCKS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BLOCKS; b++) begin
        st_q[b]  <= ST_UNC;
        own_q[b] <= '0;
        shr_q[b] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_idx]  <= wr_st;
      own_q[wr_idx] <= wr_own;
      shr_q[wr_idx] <= wr_shr;
    end
  end

  assign rd_st  = st_q[rd_idx];
  assign rd_own = own_q[rd_idx];
  assign rd_shr = shr_q[rd_idx];

  // R4
  mod_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_st == ST_MOD) |-> ($onehot(wr_shr) && wr_shr[wr_own]));

  // R3
  shared_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_st == ST_SHD) |-> (wr_shr != '0));
endmodule

// File: rtl/coh_dir_policy.sv
module coh_dir_policy
  import coh_dir_pkg::*;
#(
  parameter int NODES = 8,
  localparam int NW = $clog2(NODES)
) (
  input  blk_state_e       cur_st,
  input  logic [NW-1:0]    cur_own,
  input  logic [NODES-1:0] cur_shr,
  input  logic [1:0]       kind,
  input  logic [NW-1:0]    node,
  output blk_state_e       nxt_st,
  output logic [NW-1:0]    nxt_own,
  output logic [NODES-1:0] nxt_shr,
  output logic [NODES-1:0] inv_mask,
  output logic [1:0]       fin_kind,
  output logic [NW-1:0]    fin_dst
);
  function automatic logic [NODES-1:0] node_bit(input logic [NW-1:0] n);
    return {{(NODES-1){1'b0}}, 1'b1} << n;
  endfunction

  logic is_owner, wants_excl, is_sharer;
  assign is_owner   = (cur_st == ST_MOD) && (cur_own == node);
  assign wants_excl = (kind == RQ_RDX) || (kind == RQ_UPG);
  assign is_sharer  = cur_shr[node];

  always_comb begin
    nxt_st   = cur_st;
    nxt_own  = cur_own;
    nxt_shr  = cur_shr;
    inv_mask = '0;
    fin_kind = MS_DATA;
    fin_dst  = node;
    if (is_owner) begin
      fin_kind = MS_ACK;
    end else if (!wants_excl) begin
      nxt_st = ST_SHD;
      if (cur_st == ST_MOD) begin
        fin_kind = MS_INTV;
        fin_dst  = cur_own;
        nxt_shr  = node_bit(cur_own) | node_bit(node);
      end else begin
        nxt_shr  = cur_shr | node_bit(node);
      end
    end else begin
      nxt_st  = ST_MOD;
      nxt_own = node;
      nxt_shr = node_bit(node);
      if (cur_st == ST_MOD) begin
        fin_kind = MS_INTV;
        fin_dst  = cur_own;
      end else begin
        inv_mask = cur_shr & ~node_bit(node);
        if (kind == RQ_UPG && cur_st == ST_SHD && is_sharer)
          fin_kind = MS_ACK;
      end
    end
  end
endmodule

// File: rtl/coh_msg_seq.sv
module coh_msg_seq
  import coh_dir_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int BLOCKS = 16,
  localparam int NW = $clog2(NODES),
  localparam int BW = $clog2(BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NODES-1:0] ld_inv,
  input  logic [1:0]       ld_kind,
  input  logic [NW-1:0]    ld_dst,
  input  logic [NW-1:0]    ld_req,
  input  logic [BW-1:0]    ld_blk,
  output logic             busy,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [1:0]       msg_kind,
  output logic [NW-1:0]    msg_dst,
  output logic [NW-1:0]    msg_req,
  output logic [BW-1:0]    msg_blk
);
  function automatic logic [NW-1:0] lowest_set(input logic [NODES-1:0] m);
    logic [NW-1:0] r;
    r = '0;
    for (int i = NODES - 1; i >= 0; i--)
      if (m[i]) r = i[NW-1:0];
    return r;
  endfunction

  logic             busy_q;
  logic [NODES-1:0] inv_q;
  logic [1:0]       fkind_q;
  logic [NW-1:0]    fdst_q, req_q;
  logic [BW-1:0]    blk_q;
  logic             inv_phase, take, last_take;
  logic [NW-1:0]    inv_tgt;

  assign inv_phase = (inv_q != '0);
  assign inv_tgt   = lowest_set(inv_q);
  assign take      = busy_q && msg_ready;
  assign last_take = take && !inv_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      inv_q   <= '0;
      fkind_q <= MS_DATA;
      fdst_q  <= '0;
      req_q   <= '0;
      blk_q   <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      inv_q   <= ld_inv;
      fkind_q <= ld_kind;
      fdst_q  <= ld_dst;
      req_q   <= ld_req;
      blk_q   <= ld_blk;
    end else if (take) begin
      if (inv_phase) inv_q[inv_tgt] <= 1'b0;
      else           busy_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign msg_valid = busy_q;
  assign msg_kind  = inv_phase ? MS_INV : fkind_q;
  assign msg_dst   = inv_phase ? inv_tgt : fdst_q;
  assign msg_req   = req_q;
  assign msg_blk   = blk_q;

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) && $stable(msg_dst)
                                   && $stable(msg_blk) && $stable(msg_req)));

  // R5
  no_self_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == MS_INV) |-> (msg_dst != msg_req));

  // R10
  no_reload_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);

  // R10
  done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> !busy_q);
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
  import coh_dir_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int BLOCKS = 16,
  localparam int NW = $clog2(NODES),
  localparam int BW = $clog2(BLOCKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [NW-1:0] req_node,
  input  logic [BW-1:0] req_blk,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [1:0]    msg_kind,
  output logic [NW-1:0] msg_dst,
  output logic [NW-1:0] msg_req,
  output logic [BW-1:0] msg_blk
);
  blk_state_e       cur_st, nxt_st;
  logic [NW-1:0]    cur_own, nxt_own, fin_dst;
  logic [NODES-1:0] cur_shr, nxt_shr, inv_mask;
  logic [1:0]       fin_kind;
  logic             busy, accept;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  coh_dir_table #(.NODES(NODES), .BLOCKS(BLOCKS)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(req_blk), .rd_st(cur_st), .rd_own(cur_own), .rd_shr(cur_shr),
    .wr_en(accept), .wr_idx(req_blk), .wr_st(nxt_st), .wr_own(nxt_own), .wr_shr(nxt_shr)
  );

  coh_dir_policy #(.NODES(NODES)) u_policy (
    .cur_st(cur_st), .cur_own(cur_own), .cur_shr(cur_shr),
    .kind(req_kind), .node(req_node),
    .nxt_st(nxt_st), .nxt_own(nxt_own), .nxt_shr(nxt_shr),
    .inv_mask(inv_mask), .fin_kind(fin_kind), .fin_dst(fin_dst)
  );

  coh_msg_seq #(.NODES(NODES), .BLOCKS(BLOCKS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .ld_inv(inv_mask), .ld_kind(fin_kind), .ld_dst(fin_dst),
    .ld_req(req_node), .ld_blk(req_blk),
    .busy(busy), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_kind(msg_kind), .msg_dst(msg_dst), .msg_req(msg_req), .msg_blk(msg_blk)
  );

  // R5
  inv_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (((inv_mask & ~cur_shr) == '0) && !inv_mask[req_node]));

  // R10
  accept_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (msg_valid && !req_ready && msg_blk == $past(req_blk)));

  // R8
  intv_targets_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fin_kind == MS_INTV) |-> (cur_st == ST_MOD && fin_dst == cur_own
                                         && cur_own != req_node));
endmodule

// File: tb/coh_home_dir_test.sv
module coh_home_dir_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [2:0] req_node = 3'd0;
  logic [3:0] req_blk = 4'd0;
  logic       msg_valid;
  logic       msg_ready = 1'b1;
  logic [1:0] msg_kind;
  logic [2:0] msg_dst, msg_req;
  logic [3:0] msg_blk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  coh_home_dir uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_node(req_node), .req_blk(req_blk),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_dst(msg_dst), .msg_req(msg_req), .msg_blk(msg_blk)
  );

  // bench-side directory: state 0 uncached, 1 shared, 2 modified
  int       m_st  [16];
  int       m_own [16];
  bit [7:0] m_shr [16];

  int    e_kind [9];
  int    e_dst  [9];
  string e_tag  [9];
  int    e_cnt;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // build expected message list and update model
  task automatic predict(input int k, input int n, input int b, input string force_tag);
    int st; int own; bit [7:0] shr; bit excl; string t;
    st = m_st[b]; own = m_own[b]; shr = m_shr[b];
    excl = (k == 1) || (k == 2);
    e_cnt = 0;
    if (st == 2 && own == n) begin
      t = "R9";
      e_kind[0] = 3; e_dst[0] = n; e_cnt = 1;
    end else if (st == 2) begin
      t = excl ? "R8" : "R3";
      e_kind[0] = 1; e_dst[0] = own; e_cnt = 1;
      if (excl) begin m_own[b] = n; m_shr[b] = 8'(1 << n); end
      else begin m_st[b] = 1; m_shr[b] = 8'((1 << own) | (1 << n)); end
    end else if (!excl) begin
      t = "R2";
      e_kind[0] = 2; e_dst[0] = n; e_cnt = 1;
      m_st[b] = 1; m_shr[b] = shr | 8'(1 << n);
    end else begin
      for (int i = 0; i < 8; i++)
        if (shr[i] && i != n) begin
          e_kind[e_cnt] = 0; e_dst[e_cnt] = i; e_tag[e_cnt] = "R5"; e_cnt++;
        end
      if (k == 2 && st == 1 && shr[n]) begin t = "R6"; e_kind[e_cnt] = 3; end
      else begin t = (k == 2) ? "R7" : "R4"; e_kind[e_cnt] = 2; end
      e_dst[e_cnt] = n;
      e_cnt++;
      m_st[b] = 2; m_own[b] = n; m_shr[b] = 8'(1 << n);
    end
    if (force_tag != "") t = force_tag;
    e_tag[e_cnt-1] = t;
  endtask

  task automatic do_req(input int k, input int n, input int b, input bit stall, input string force_tag);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "req_ready idle", int'(req_ready), 1);
    req_valid = 1'b1; req_kind = 2'(k); req_node = 3'(n); req_blk = 4'(b);
    predict(k, n, b, force_tag);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "req_ready busy", int'(req_ready), 0);
    for (int i = 0; i < e_cnt; i++) begin
      if (stall) begin
        msg_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(msg_valid == 1'b1 && int'(msg_kind) == e_kind[i] && int'(msg_dst) == e_dst[i],
            "R11", "held msg kind*8+dst", int'(msg_kind) * 8 + int'(msg_dst), e_kind[i] * 8 + e_dst[i]);
      end
      chk(msg_valid == 1'b1 && int'(msg_kind) == e_kind[i] && int'(msg_dst) == e_dst[i]
          && int'(msg_req) == n && int'(msg_blk) == b,
          e_tag[i], "msg valid*64+kind*8+dst",
          int'(msg_valid) * 64 + int'(msg_kind) * 8 + int'(msg_dst),
          64 + e_kind[i] * 8 + e_dst[i]);
      msg_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    chk(msg_valid == 1'b0 && req_ready == 1'b1, "R10", "after last valid*2+ready",
        int'(msg_valid) * 2 + int'(req_ready), 1);
  endtask

  initial begin
    bit [15:0] lf;
    for (int b = 0; b < 16; b++) begin m_st[b] = 0; m_own[b] = 0; m_shr[b] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && msg_valid == 1'b0, "R1", "reset ready*2+valid",
        int'(req_ready) * 2 + int'(msg_valid), 2);
    // directed
    do_req(0, 1, 0, 0, "R1");
    do_req(0, 2, 0, 0, "");
    do_req(0, 5, 0, 1, "");
    do_req(1, 3, 0, 0, "");
    do_req(0, 6, 0, 0, "");
    do_req(2, 6, 0, 1, "");
    do_req(2, 0, 0, 0, "");
    do_req(0, 0, 0, 0, "");
    do_req(0, 4, 1, 0, "");
    do_req(2, 7, 1, 0, "");
    do_req(3, 2, 1, 0, "");
    do_req(0, 1, 2, 0, "R12");
    // first touch of every block after that work elsewhere
    for (int b = 3; b < 16; b++) do_req(1, b % 8, b, 0, "R12");
    // pseudo-random sweep
    lf = 16'hACE1;
    for (int r = 0; r < 600; r++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_req(int'(lf[1:0]) == 3 ? 0 : int'(lf[1:0]), int'(lf[4:2]), int'(lf[8:6]) & 3,
             (r % 5) == 2, "");
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule